// File: doc/BRIEF.md
# Legacy Interrupt Line Merger and Upstream Message Source

This block follows the four legacy interrupt lines (A, B, C and D) that every downstream port of a switch can raise or drop. Each port delivers events that name a line and say whether that line goes high or low. The block keeps one level bit per port and line, and forms the switch-wide level of each line as the OR of that line over all ports.

When a merged line changes level, the block asks the upstream port to send an assert or deassert message for that line. Requests leave on a valid/ready stream carrying the message kind and the line number. The request in the output register is held, unchanged, until the consumer takes it. If several lines change at once, the requests are issued one per cycle, lowest line first. While the stream is stalled, the block tracks only the difference between the level last announced and the present merged level. A line that rises and falls back during a stall is therefore never announced. Per-port and merged levels are plain status outputs.

Top module: `intx_agg`

## Requirements
- R1: An event on port p with `evt_assert`=1 sets bit p*4+line of `port_levels`, and with `evt_assert`=0 clears it, visible after the clock edge that samples the event. Line codes are 0=A, 1=B, 2=C, 3=D.
- R2: Bit n of `agg_levels` is 1 exactly when bit n is set for at least one port in `port_levels`.
- R3: When a merged line rises, a request with `msg_is_assert`=1 and `msg_line` equal to that line's code is issued. With the output idle, `msg_valid` rises one cycle after the level change is visible.
- R4: When a merged line falls, a request with `msg_is_assert`=0 and that line's code is issued.
- R5: An event that leaves the merged level unchanged produces no request. This covers a repeated assert, a repeated deassert, and a change from a second port on a line that is already high.
- R6: Lines that change in the same cycle are issued in the order A, B, C, D, one request per cycle while `msg_ready` is 1.
- R7: While `msg_valid`=1 and `msg_ready`=0, `msg_valid`, `msg_is_assert` and `msg_line` stay constant.
- R8: For each line, accepted requests alternate between assert and deassert, and the first one after reset is an assert.
- R9: After reset, every level is 0 and `msg_valid` is 0.
- R10: If a merged line returns to its last announced level before its request has been loaded into the output register, no request is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | NUM_PORTS | Per-port event strobe |
| evt_assert | input | NUM_PORTS | Per-port event kind: 1 raise, 0 drop |
| evt_line | input | NUM_PORTS*2 | Per-port line code; bits 2p+1:2p belong to port p |
| port_levels | output | NUM_PORTS*4 | Per-port line levels; bit p*4+n is line n of port p |
| agg_levels | output | 4 | Merged level of each line |
| msg_valid | output | 1 | Request present |
| msg_ready | input | 1 | Consumer accepts the request |
| msg_is_assert | output | 1 | 1 requests an assert message, 0 a deassert message |
| msg_line | output | 2 | Line code of the request |

## Verification
The hardest situation to reach is R10: a line that rises and falls while its request has not yet been loaded. The stimulus creates it by holding `msg_ready` low after one request is already in the output register. It then raises and drops a second line on consecutive cycles, and raises a third line and keeps it high. When `msg_ready` is released, only the held request and the third line's assert may appear. A simultaneous raise on all four ports, each on a different line, exercises the fixed issue order and the one-per-cycle rate.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned INTX_LINES = 4;
  localparam int unsigned INTX_IDX_W = $clog2(INTX_LINES);
  typedef logic [INTX_IDX_W-1:0] intx_idx_t;
  typedef logic [INTX_LINES-1:0] intx_vec_t;
endpackage

// File: rtl/intx_port_tracker.sv
module intx_port_tracker #(
  parameter int unsigned LINES = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic             ev_assert,
  input  logic [IDX_W-1:0] ev_line,
  output logic [LINES-1:0] levels
);
  always_ff @(posedge clk) begin
    if (rst) begin
      levels <= '0;
    end else if (ev_valid) begin
      levels[ev_line] <= ev_assert;
    end
  end
endmodule

// File: rtl/intx_line_merge.sv
module intx_line_merge #(
  parameter int unsigned PORTS = 4,
  parameter int unsigned LINES = 4
) (
  input  logic [PORTS*LINES-1:0] port_levels,
  output logic [LINES-1:0]       merged
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    always_comb begin
      merged[n] = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
        merged[n] = merged[n] | port_levels[p*LINES + n];
      end
    end
  end
endmodule

// File: rtl/intx_msg_issuer.sv
module intx_msg_issuer #(
  parameter int unsigned LINES = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] merged,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic             msg_is_assert,
  output logic [IDX_W-1:0] msg_line
);
  // told: level last loaded into the output register, per line
  logic [LINES-1:0] told;
  logic [LINES-1:0] pend;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic             load;

  assign pend = merged ^ told;

  // lowest pending line wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign load = found && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      told          <= '0;
      msg_valid     <= 1'b0;
      msg_is_assert <= 1'b0;
      msg_line      <= '0;
    end else if (load) begin
      msg_valid     <= 1'b1;
      msg_line      <= pick;
      msg_is_assert <= merged[pick];
      told[pick]    <= merged[pick];
    end else if (msg_ready) begin
      msg_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/intx_agg.sv
module intx_agg
  import intx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             evt_valid,
  input  logic [NUM_PORTS-1:0]             evt_assert,
  input  logic [NUM_PORTS*INTX_IDX_W-1:0]  evt_line,
  output logic [NUM_PORTS*INTX_LINES-1:0]  port_levels,
  output logic [INTX_LINES-1:0]            agg_levels,
  output logic                             msg_valid,
  input  logic                             msg_ready,
  output logic                             msg_is_assert,
  output logic [INTX_IDX_W-1:0]            msg_line
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    intx_port_tracker #(.LINES(INTX_LINES), .IDX_W(INTX_IDX_W)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .ev_valid  (evt_valid[p]),
      .ev_assert (evt_assert[p]),
      .ev_line   (evt_line[p*INTX_IDX_W +: INTX_IDX_W]),
      .levels    (port_levels[p*INTX_LINES +: INTX_LINES])
    );
  end

  intx_line_merge #(.PORTS(NUM_PORTS), .LINES(INTX_LINES)) u_merge (
    .port_levels (port_levels),
    .merged      (agg_levels)
  );

  intx_msg_issuer #(.LINES(INTX_LINES), .IDX_W(INTX_IDX_W)) u_issue (
    .clk           (clk),
    .rst           (rst),
    .merged        (agg_levels),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_is_assert (msg_is_assert),
    .msg_line      (msg_line)
  );
endmodule

// File: rtl/intx_agg_props.sv
module intx_agg_props
  import intx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_PORTS*INTX_LINES-1:0] port_levels,
  input logic [INTX_LINES-1:0]           agg_levels,
  input logic                            msg_valid,
  input logic                            msg_ready,
  input logic                            msg_is_assert,
  input logic [INTX_IDX_W-1:0]           msg_line
);
  // level of each line as seen by the consumer through accepted requests
  logic [INTX_LINES-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (msg_valid && msg_ready) seen[msg_line] <= msg_is_assert;
  end

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!msg_valid && agg_levels == '0 && port_levels == '0));

  a_r7_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_line) && $stable(msg_is_assert)));

  a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |-> (msg_is_assert != seen[msg_line]));

  a_r2_any_level: assert property (@(posedge clk) disable iff (rst)
    (agg_levels != '0) == (port_levels != '0));
endmodule

bind intx_agg intx_agg_props #(.NUM_PORTS(NUM_PORTS)) u_props (
  .clk           (clk),
  .rst           (rst),
  .port_levels   (port_levels),
  .agg_levels    (agg_levels),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_is_assert (msg_is_assert),
  .msg_line      (msg_line)
);

// File: tb/intx_agg_bench.sv
module intx_agg_bench;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] evt_valid = '0;
  logic [NP-1:0] evt_assert = '0;
  logic [NP*2-1:0] evt_line = '0;
  logic [NP*4-1:0] port_levels;
  logic [3:0]    agg_levels;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic          msg_is_assert;
  logic [1:0]    msg_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [2:0] expq[$];   // {is_assert, line}

  always #4 clk = ~clk;  // 125 MHz

  intx_agg #(.NUM_PORTS(NP)) u_intx_agg (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_assert(evt_assert),
    .evt_line(evt_line), .port_levels(port_levels), .agg_levels(agg_levels),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_is_assert(msg_is_assert), .msg_line(msg_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic expect_msg(input logic a, input logic [1:0] ln);
    expq.push_back({a, ln});
  endtask

  task automatic put_evt(input int p, input logic a, input logic [1:0] ln);
    evt_valid[p] = 1'b1;
    evt_assert[p] = a;
    evt_line[p*2 +: 2] = ln;
  endtask

  // present events for one edge, then clear them
  task automatic tick();
    @(negedge clk);
    evt_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: samples mid low phase
  always @(negedge clk) begin
    #2;
    if (!rst && msg_valid && msg_ready) begin
      if (expq.size() == 0) begin
        chk("R5 unexpected request", {29'd0, msg_is_assert, msg_line}, 32'h7);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk("R3/R4/R6 request", {29'd0, msg_is_assert, msg_line}, {29'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R9 port levels", 32'(port_levels), 0);
    chk("R9 merged levels", 32'(agg_levels), 0);
    chk("R9 no request", 32'(msg_valid), 0);

    // R1/R3: port 0 raises A
    put_evt(0, 1'b1, 2'd0); expect_msg(1'b1, 2'd0);
    tick(); #1;
    chk("R1 port0 A set", 32'(port_levels[0]), 1);
    chk("R2 merged A", 32'(agg_levels), 32'h1);
    chk("R3 not yet valid", 32'(msg_valid), 0);
    @(negedge clk); #1;
    chk("R3 request valid", 32'(msg_valid), 1);
    idle(3);

    // R5: second port on A, repeats, first port drops
    put_evt(1, 1'b1, 2'd0); tick();
    put_evt(1, 1'b1, 2'd0); tick();
    put_evt(0, 1'b0, 2'd0); tick(); #1;
    chk("R1 port0 A cleared", 32'(port_levels[0]), 0);
    chk("R2 A held by port1", 32'(agg_levels[0]), 1);
    put_evt(0, 1'b0, 2'd0); tick();
    idle(3);
    chk("R5 no traffic", 32'(expq.size()), 0);
    // R4: last holder drops A
    put_evt(1, 1'b0, 2'd0); expect_msg(1'b0, 2'd0); tick();
    idle(4);

    // R6: all four lines at once, from four ports
    put_evt(0, 1'b1, 2'd3); put_evt(1, 1'b1, 2'd1);
    put_evt(2, 1'b1, 2'd2); put_evt(3, 1'b1, 2'd0);
    expect_msg(1'b1, 2'd0); expect_msg(1'b1, 2'd1);
    expect_msg(1'b1, 2'd2); expect_msg(1'b1, 2'd3);
    tick(); #1;
    chk("R2 all merged", 32'(agg_levels), 32'hF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #3;
      chk("R6 back-to-back", 32'(msg_valid), 1);
    end
    @(negedge clk); #3;
    chk("R6 burst ends", 32'(msg_valid), 0);
    put_evt(0, 1'b0, 2'd3); put_evt(1, 1'b0, 2'd1);
    put_evt(2, 1'b0, 2'd2); put_evt(3, 1'b0, 2'd0);
    expect_msg(1'b0, 2'd0); expect_msg(1'b0, 2'd1);
    expect_msg(1'b0, 2'd2); expect_msg(1'b0, 2'd3);
    tick();
    idle(7);
    chk("R8 drained alternating", 32'(expq.size()), 0);

    // R7/R10: stall the stream
    msg_ready = 1'b0;
    put_evt(2, 1'b1, 2'd1); expect_msg(1'b1, 2'd1); tick();
    idle(2); #1;
    chk("R7 held valid", 32'(msg_valid), 1);
    chk("R7 held payload", {30'd0, msg_is_assert, msg_line}, 32'h5);
    put_evt(3, 1'b1, 2'd2); tick();
    put_evt(3, 1'b0, 2'd2); put_evt(0, 1'b1, 2'd0); expect_msg(1'b1, 2'd0); tick();
    idle(2); #1;
    chk("R7 still held", {29'd0, msg_valid, msg_is_assert, msg_line}, 32'hD);
    @(negedge clk);
    msg_ready = 1'b1;
    idle(5);
    chk("R10 C cancelled", 32'(expq.size()), 0);

    // R8: close B and A
    put_evt(2, 1'b0, 2'd1); put_evt(0, 1'b0, 2'd0);
    expect_msg(1'b0, 2'd0); expect_msg(1'b0, 2'd1);
    tick();
    idle(5);
    chk("R8 final drain", 32'(expq.size()), 0);
    chk("R2 final merged", 32'(agg_levels), 0);
    summary();
  end
endmodule